// File: doc/BRIEF.md
# Table-Prescaled Single-Channel PWM Generator

This block produces one pulse-width-modulated output from a fast reference clock. A four-bit code picks a clock divisor from a fixed, irregular set of values. Each divided tick advances a 16-bit period counter. The output is at its active level while the counter is below the programmed duty count. A second bit selects whether the active level is high or low.

Software sees two 32-bit words through a plain write/read port: a control word and a period/duty word. The control word carries the divisor code, an enable, the active-level choice and a clock-run bit. Software changes the divisor in three steps: it clears the clock-run bit, writes the new code, then sets the bit again. While the bit is clear the divider and the counter are frozen.

New period and duty values are applied only at a period boundary, so the output never shows a partly updated cycle.

Top module: `tick_pwm`

## Requirements
- R1: Byte offset 0 is the control word and byte offset 4 is the period/duty word. Each reads back all 32 bits exactly as last written. A write or read at any other offset (offsets 1-3, 5-7) changes nothing, and such a read returns 0.
- R2: Control word fields are as follows. Bits [3:0] hold the divisor code. Bit 4 is the enable. Bit 5 is the active level: 1 makes the active output 1, and 0 makes the active output 0. Bit 6 is clock-run, where 1 lets the divider advance. The output always shows the inverse of bit 5 when it is not active.
- R3: In the period/duty word, bits [31:16] hold the period P and bits [15:0] hold the duty D. With divisor N, let k count the clocks after the edge that enables the channel. Output sample k is active exactly when floor(k/N) mod (P+1) < D. This holds up to P = 0xFFFF.
- R4: The divisor codes map as follows: 0->120, 1->180, 2->240, 3->360, 4->480, 8->12000, 9->24000, 10->36000, 11->48000, 12->72000, 15->1.
- R5: D = 0 gives a constant inactive output. D > P gives a constant active output.
- R6: Codes 5, 6, 7, 13 and 14 produce no tick. They hold both counters at zero and keep the output inactive. Selecting a valid code afterwards restarts the waveform from count zero.
- R7: While clock-run is 0, both counters and the output hold their values. A divisor code written during that time does not move the output. Setting clock-run again resumes from the held state.
- R8: Clearing the enable makes the output inactive from the next clock and zeroes the counters. Re-enabling restarts the waveform from count zero.
- R9: A period/duty write made mid-period takes effect at the first wrap of the period counter. The wrap must happen at least one clock after the write edge. The new period starts from count zero.
- R10: After a clocked reset with rst_n low, both words read 0 and the output is 1. This is the inactive level for active level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Byte offset of the accessed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the word at reg_addr, combinational |
| pwm_out | output | 1 | Modulated output |

## Verification
A register write lands on the clock edge inside the write, and the output reflects it right after that edge. The bench therefore numbers samples from that edge and computes every expected level from the R3 formula, using the edge index. A period/duty write is expected to take effect at the wrap edge computed from R9. A clock-run change is expected one edge after the write: first as a frozen level, then as a shifted index. The driver queues one expected level per clock at the falling edge. The monitor compares the output a quarter period after the next rising edge. Register reads are checked combinationally, one time step after the address is set.

// File: rtl/tick_pwm_pkg.sv
// Shared constants and the divisor lookup for the table-prescaled PWM.
// Assumes a 4-bit divisor code; a returned divisor of zero marks a reserved code.
package tick_pwm_pkg;
    localparam int CODE_W   = 4;
    localparam int DIV_MAX  = 72000;
    localparam int DIV_W    = $clog2(DIV_MAX + 1);
    localparam int BIT_EN   = 4;
    localparam int BIT_LVL  = 5;
    localparam int BIT_RUN  = 6;

    // Maps a divisor code to its clock divisor; 0 means reserved.
    function automatic logic [DIV_W-1:0] divisor_of(input logic [CODE_W-1:0] code);
        case (code)
            4'd0:    divisor_of = DIV_W'(120);
            4'd1:    divisor_of = DIV_W'(180);
            4'd2:    divisor_of = DIV_W'(240);
            4'd3:    divisor_of = DIV_W'(360);
            4'd4:    divisor_of = DIV_W'(480);
            4'd8:    divisor_of = DIV_W'(12000);
            4'd9:    divisor_of = DIV_W'(24000);
            4'd10:   divisor_of = DIV_W'(36000);
            4'd11:   divisor_of = DIV_W'(48000);
            4'd12:   divisor_of = DIV_W'(72000);
            4'd15:   divisor_of = DIV_W'(1);
            default: divisor_of = '0;
        endcase
    endfunction
endpackage

// File: rtl/tick_pwm_regs.sv
// Register file: control word and period/duty word with combinational read.
// Assumes word-aligned byte offsets; other offsets are ignored and read as zero.
module tick_pwm_regs #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] prd_q
);
    localparam int WORD_BITS = ADDR_W - 2;

    logic aligned, sel_ctrl, sel_prd;

    // Decodes the two word offsets.
    always_comb begin
        aligned  = (addr[1:0] == 2'b00);
        sel_ctrl = aligned && (addr[ADDR_W-1:2] == WORD_BITS'(0));
        sel_prd  = aligned && (addr[ADDR_W-1:2] == WORD_BITS'(1));
    end

    // Stores written words; reset clears both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            prd_q  <= '0;
        end else if (wr) begin
            if (sel_ctrl) ctrl_q <= wdata;
            if (sel_prd)  prd_q  <= wdata;
        end
    end

    // Returns the addressed word or zero.
    always_comb begin
        if (sel_ctrl)     rdata = ctrl_q;
        else if (sel_prd) rdata = prd_q;
        else              rdata = '0;
    end
endmodule

// File: rtl/tick_pwm_prescaler.sv
// Divides the reference clock by the table divisor and emits one-cycle ticks.
// Assumes the code may change only while run is low; a stale count past the
// new limit is wrapped on the next advance.
module tick_pwm_prescaler
    import tick_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    input  logic              en,
    input  logic              run,
    output logic              valid,
    output logic              idle,
    output logic              tick,
    output logic [DIV_W-1:0]  div_cnt
);
    logic [DIV_W-1:0] divisor, limit;

    // Looks up the divisor and derives the idle condition.
    always_comb begin
        divisor = divisor_of(code);
        valid   = (divisor != '0);
        limit   = divisor - DIV_W'(1);
        idle    = !en || !valid;
        tick    = !idle && run && (div_cnt >= limit);
    end

    // Advances the divider while running; clears it while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || idle)
            div_cnt <= '0;
        else if (run)
            div_cnt <= (div_cnt >= limit) ? '0 : div_cnt + DIV_W'(1);
    end
endmodule

// File: rtl/tick_pwm_wave.sv
// Period counter with boundary-latched period/duty and output level select.
// Assumes tick is a single-cycle strobe and never high while idle.
module tick_pwm_wave #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle,
    input  logic             tick,
    input  logic             act_lvl,
    input  logic [CNT_W-1:0] prd_in,
    input  logic [CNT_W-1:0] duty_in,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] prd_w,
    output logic [CNT_W-1:0] duty_w,
    output logic             pwm_out
);
    logic wrap, active;

    // Detects the last tick of a period.
    always_comb wrap = (cnt >= prd_w);

    // Counts ticks and reloads working values at each wrap or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            prd_w  <= '0;
            duty_w <= '0;
        end else if (idle) begin
            cnt    <= '0;
            prd_w  <= prd_in;
            duty_w <= duty_in;
        end else if (tick) begin
            if (wrap) begin
                cnt    <= '0;
                prd_w  <= prd_in;
                duty_w <= duty_in;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // Selects active or inactive level.
    always_comb begin
        active  = !idle && (cnt < duty_w);
        pwm_out = active ? act_lvl : !act_lvl;
    end
endmodule

// File: rtl/tick_pwm.sv
// Top of the table-prescaled single-channel PWM generator.
// Assumes a 32-bit register word holding two CNT_W fields in the period word.
module tick_pwm
    import tick_pwm_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              pwm_out
);
    logic [DATA_W-1:0] ctrl_q, prd_q;
    logic              en, run, act_lvl, valid, idle, tick;
    logic [CODE_W-1:0] code;
    logic [DIV_W-1:0]  div_cnt;
    logic [CNT_W-1:0]  per_cnt, prd_w, duty_w;

    tick_pwm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .ctrl_q(ctrl_q), .prd_q(prd_q)
    );

    // Splits the control word into its fields.
    always_comb begin
        code    = ctrl_q[CODE_W-1:0];
        en      = ctrl_q[BIT_EN];
        act_lvl = ctrl_q[BIT_LVL];
        run     = ctrl_q[BIT_RUN];
    end

    tick_pwm_prescaler u_pre (
        .clk(clk), .rst_n(rst_n), .code(code), .en(en), .run(run),
        .valid(valid), .idle(idle), .tick(tick), .div_cnt(div_cnt)
    );

    tick_pwm_wave #(.CNT_W(CNT_W)) u_wave (
        .clk(clk), .rst_n(rst_n), .idle(idle), .tick(tick), .act_lvl(act_lvl),
        .prd_in(prd_q[2*CNT_W-1:CNT_W]), .duty_in(prd_q[CNT_W-1:0]),
        .cnt(per_cnt), .prd_w(prd_w), .duty_w(duty_w), .pwm_out(pwm_out)
    );
endmodule

// File: rtl/tick_pwm_checker.sv
// Temporal checks on the PWM internals, attached to the top by bind.
module tick_pwm_checker
    import tick_pwm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] ctrl_q,
    input logic [DATA_W-1:0] prd_q,
    input logic              idle,
    input logic              run,
    input logic              valid,
    input logic              act_lvl,
    input logic              tick,
    input logic [DIV_W-1:0]  div_cnt,
    input logic [CNT_W-1:0]  per_cnt,
    input logic [CNT_W-1:0]  prd_w,
    input logic              pwm_out
);
    // R10: reset clears both words
    a_r10_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (ctrl_q == '0 && prd_q == '0));

    // R6: reserved code never ticks
    a_r6_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> !tick);

    // R6, R8: idle zeroes both counters
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        idle |=> (per_cnt == '0 && div_cnt == '0));

    // R8: idle output at inactive level
    a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (pwm_out == !act_lvl));

    // R7: clock-run low freezes the counters
    a_r7_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !idle) |=> ($stable(per_cnt) && $stable(div_cnt)));

    // R3: last tick of a period wraps to zero
    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && per_cnt >= prd_w) |=> (per_cnt == '0));

    // R3: count advances by one on a non-final tick
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && per_cnt < prd_w) |=> (per_cnt == $past(per_cnt) + CNT_W'(1)));
endmodule

bind tick_pwm tick_pwm_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .prd_q(prd_q), .idle(idle),
    .run(run), .valid(valid), .act_lvl(act_lvl), .tick(tick),
    .div_cnt(div_cnt), .per_cnt(per_cnt), .prd_w(prd_w), .pwm_out(pwm_out)
);

// File: tb/tb_tick_pwm.sv
// Scoreboard bench: the driver queues one expected level per clock, the
// monitor compares pwm_out a quarter period after each rising edge.
module tb_tick_pwm;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYC    = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pwm_out;

    int n_chk = 0;
    int n_err = 0;
    int kk = 0;

    logic  exp_q[$];
    string tag_q[$];

    // model state
    bit m_run = 0, m_pol = 0, m_swap = 0, m_freeze = 0;
    int m_div = 1, m_P = 0, m_D = 0, m_P2 = 0, m_D2 = 0, m_B = 0, m_fk = 0, m_off = 0;

    tick_pwm dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: pop and compare one level per clock.
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (exp_q.size() > 0) begin
            logic  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(pwm_out === e, t, {31'b0, pwm_out}, {31'b0, e});
        end
    end

    function automatic logic base(int k);
        int P, D, k2, idx;
        P = m_P; D = m_D; k2 = k;
        if (m_swap && k >= m_B) begin
            k2 = k - m_B; P = m_P2; D = m_D2;
        end
        idx = (k2 / m_div) % (P + 1);
        return (idx < D) ? m_pol : !m_pol;
    endfunction

    function automatic logic lvl(int k);
        if (!m_run) return !m_pol;
        if (m_freeze) return base(m_fk);
        return base(k - m_off);
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        kk++;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        check(reg_rdata === exp, tag, reg_rdata, exp);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            kk++;
            exp_q.push_back(lvl(kk));
            tag_q.push_back(tag);
            @(negedge clk);
        end
    endtask

    function automatic logic [31:0] ctrl(input int code, input bit en, input bit pol, input bit gate);
        return {25'b0, gate, pol, en, code[3:0]};
    endfunction

    task automatic start(input int code, input int div, input bit pol, input int P, input int D);
        wr(3'd0, ctrl(code, 1'b0, pol, 1'b1));
        wr(3'd4, {P[15:0], D[15:0]});
        wr(3'd0, ctrl(code, 1'b1, pol, 1'b1));
        kk = 0;
        m_run = 1; m_pol = pol; m_div = div; m_P = P; m_D = D;
        m_swap = 0; m_freeze = 0; m_off = 0;
    endtask

    initial begin
        #(CLK_PERIOD * MAX_CYC);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int codes[6];
        int divs[6];
        int res[5];
        codes = '{0, 1, 2, 3, 4, 8};
        divs  = '{120, 180, 240, 360, 480, 12000};
        res   = '{5, 6, 7, 13, 14};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        rd_chk(3'd0, 32'h0, "R10 ctrl after reset");
        rd_chk(3'd4, 32'h0, "R10 period after reset");
        check(pwm_out === 1'b1, "R10 output after reset", {31'b0, pwm_out}, 32'h1);

        // R1 readback and ignored offsets
        wr(3'd0, 32'hA5A5_0F00);
        wr(3'd4, 32'h1234_5678);
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd6, 32'hFFFF_FFFF);
        rd_chk(3'd0, 32'hA5A5_0F00, "R1 ctrl readback");
        rd_chk(3'd4, 32'h1234_5678, "R1 period readback");
        rd_chk(3'd2, 32'h0, "R1 unmapped read");
        rd_chk(3'd6, 32'h0, "R1 unmapped read 6");
        check(pwm_out === 1'b1, "R1 stray write no output", {31'b0, pwm_out}, 32'h1);

        // R3/R2 basic waveform, active-high, bypass code
        start(15, 1, 1'b1, 4, 2);
        run(20, "R3 P4 D2 active-high");

        // R9 mid-period update
        begin
            int k0;
            k0 = kk;
            wr(3'd4, {16'd2, 16'd1});
            m_B = k0 + 2;
            while (m_B % (m_div * (m_P + 1)) != 0) m_B++;
            m_P2 = 2; m_D2 = 1; m_swap = 1;
            run(20, "R9 update at wrap");
        end

        // R2 active-low level
        start(15, 1, 1'b0, 4, 2);
        run(15, "R2 active-low");

        // R5 duty corners
        start(15, 1, 1'b1, 4, 0);
        run(10, "R5 duty zero");
        start(15, 1, 1'b1, 4, 7);
        run(10, "R5 duty above period");

        // R3 largest period
        start(15, 1, 1'b1, 16'hFFFF, 16'hFFFF);
        run(20, "R3 max period");

        // R4 divisor table
        for (int i = 0; i < 6; i++) begin
            start(codes[i], divs[i], 1'b1, 1, 1);
            run(4 * divs[i] + 3, $sformatf("R4 code %0d", codes[i]));
        end

        // R6 reserved codes
        for (int i = 0; i < 5; i++) begin
            start(res[i], 1, 1'b1, 4, 2);
            m_run = 0;
            run(30, $sformatf("R6 reserved %0d", res[i]));
        end
        wr(3'd0, ctrl(15, 1'b1, 1'b1, 1'b1));
        kk = 0; m_run = 1; m_div = 1;
        run(12, "R6 restart after reserved");

        // R7 clock-run gate
        start(0, 120, 1'b1, 1, 1);
        run(130, "R7 before gate");
        wr(3'd0, ctrl(0, 1'b1, 1'b1, 1'b0));
        m_freeze = 1; m_fk = kk;
        run(200, "R7 frozen");
        wr(3'd0, ctrl(15, 1'b1, 1'b1, 1'b0));
        run(50, "R7 code change while gated");
        wr(3'd0, ctrl(0, 1'b1, 1'b1, 1'b0));
        run(5, "R7 code restore while gated");
        wr(3'd0, ctrl(0, 1'b1, 1'b1, 1'b1));
        m_off = kk - m_fk; m_freeze = 0;
        run(300, "R7 resume");

        // R8 disable and restart
        wr(3'd0, ctrl(0, 1'b0, 1'b1, 1'b1));
        m_run = 0;
        run(20, "R8 disabled");
        wr(3'd0, ctrl(15, 1'b1, 1'b1, 1'b1));
        kk = 0; m_run = 1; m_div = 1; m_off = 0;
        run(10, "R8 re-enable");

        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule